// File: doc/BRIEF.md
# Eight-Output Addressable Latch with Demultiplexer Mode

This block keeps eight output bits that a controller sets one at a time through a single data bit and a 3-bit select. Two active-low controls, an enable and a clear, are read together to pick one of four modes. The modes are hold, addressed write, clear-all, and a 3-to-8 demultiplexer. The outputs are inverted. They model active-low driver lines, so a driver that is off shows logic 1. Reset and clear both put every line in that off state.

Everything is synchronous to one system clock. The controls, data and select are sampled on each rising edge, and the output register updates on that same edge. A change at the inputs therefore appears on the outputs one clock later. While enable is low, the selected output follows the inverse of the data bit cycle by cycle. When enable goes back high, the last value shown is what stays stored. The select must be set up while enable is high and must not move while enable is low.

There are no streaming transfers here, so all pins are plain level signals with no valid/ready handshake.

Top module: `addr_latch_demux`

## Requirements
- R1: A synchronous active-high `rst` sets all of `q_n` to 1 (off) one clock later. Reset takes priority over every mode. Bit i of `q_n` is output i, and `sel[0]` is the least significant bit of the select.
- R2: With `en_n`=0 and `clr_n`=1 sampled at an edge, `q_n[sel]` equals the inverse of `din` after that edge, so the selected output follows the data each cycle.
- R3: At the first edge where `en_n` is sampled high after being low, with `clr_n`=1, `q_n` keeps the value it showed just before that edge.
- R4: During an addressed write, every output other than the selected one keeps its previous value.
- R5: With `en_n`=1 and `clr_n`=1, `q_n` does not change, whatever `din` does.
- R6: With `en_n`=1 and `clr_n`=0, all of `q_n` becomes 1 after the edge.
- R7: With `en_n`=0 and `clr_n`=0, after the edge `q_n[sel]` equals the inverse of `din` and every other bit is 1.
- R8: Changing `sel` while `en_n` is high has no effect on the outputs. `sel` must stay stable at every edge where `en_n` is sampled low.
- R9: When enable is released after demultiplexer mode, with `clr_n` back at 1, the last demultiplexer pattern stays stored and a later addressed write changes only its own bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Data bit; the selected output shows its inverse |
| sel | input | 3 | Output select, bit 0 is the LSB |
| en_n | input | 1 | Enable, active low |
| clr_n | input | 1 | Clear, active low |
| q_n | output | 8 | Inverted outputs; 1 means off |

## Verification
The checker tests the result of each mode on every cycle. In write and demultiplexer modes it checks the selected bit against the previous data bit. It checks that write mode leaves the other bits alone, that hold mode keeps the outputs stable, that clear drives all ones, and that the outputs do not move on the enable release edge. It also flags any select change at an edge where enable is low. Some behaviour only the bench's scripted sequences can show. These include how the stored pattern builds up over several writes to different outputs, the survival of a demultiplexer pattern into later writes, and the fact that a select change made with enable high leaves earlier stores untouched.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_CLEAR = 2'd2,
    MODE_DEMUX = 2'd3
  } latch_mode_e;

  localparam logic LINE_OFF = 1'b1;

  // Next value of one output line in a given mode.
  function automatic logic next_line(
    input latch_mode_e mode,
    input logic        picked,
    input logic        level,
    input logic        cur
  );
    logic r;
    unique case (mode)
      MODE_HOLD:  r = cur;
      MODE_WRITE: r = picked ? level : cur;
      MODE_CLEAR: r = LINE_OFF;
      MODE_DEMUX: r = picked ? level : LINE_OFF;
      default:    r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/addr_latch_mode.sv
module addr_latch_mode
  import addr_latch_pkg::*;
(
  input  logic        en_n,
  input  logic        clr_n,
  output latch_mode_e mode
);
  always_comb begin
    unique case ({en_n, clr_n})
      2'b11:   mode = MODE_HOLD;
      2'b01:   mode = MODE_WRITE;
      2'b10:   mode = MODE_CLEAR;
      default: mode = MODE_DEMUX;
    endcase
  end
endmodule

// File: rtl/addr_latch_select.sv
module addr_latch_select #(
  parameter int ADDR_W = 3,
  localparam int NUM_OUT = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0]  sel,
  output logic [NUM_OUT-1:0] pick
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pick
    assign pick[i] = (sel == ADDR_W'(i));
  end
endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
  import addr_latch_pkg::*;
#(
  parameter int NUM_OUT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  latch_mode_e        mode,
  input  logic [NUM_OUT-1:0] pick,
  input  logic               level,
  output logic [NUM_OUT-1:0] lines
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
    logic cell_q;
    always_ff @(posedge clk) begin
      if (rst) cell_q <= LINE_OFF;
      else     cell_q <= next_line(mode, pick[i], level, cell_q);
    end
    assign lines[i] = cell_q;
  end
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NUM_OUT = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               din,
  input  logic [ADDR_W-1:0]  sel,
  input  logic               en_n,
  input  logic               clr_n,
  output logic [NUM_OUT-1:0] q_n
);
  latch_mode_e        mode;
  logic [NUM_OUT-1:0] pick;
  logic               level;

  assign level = ~din;

  addr_latch_mode u_mode (
    .en_n  (en_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  addr_latch_select #(.ADDR_W(ADDR_W)) u_sel (
    .sel  (sel),
    .pick (pick)
  );

  addr_latch_bank #(.NUM_OUT(NUM_OUT)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .pick  (pick),
    .level (level),
    .lines (q_n)
  );
endmodule

// File: rtl/addr_latch_demux_checker.sv
module addr_latch_demux_checker #(
  parameter int ADDR_W = 3,
  localparam int NUM_OUT = 1 << ADDR_W
) (
  input logic               clk,
  input logic               rst,
  input logic               din,
  input logic [ADDR_W-1:0]  sel,
  input logic               en_n,
  input logic               clr_n,
  input logic [NUM_OUT-1:0] q_n
);
  logic en_n_prev;
  always_ff @(posedge clk) begin
    if (rst) en_n_prev <= 1'b1;
    else     en_n_prev <= en_n;
  end

  p_reset_off_r1: assert property (@(posedge clk)
    rst |=> (q_n == {NUM_OUT{1'b1}}));

  p_write_pick_r2: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr_n) |=> (q_n[$past(sel)] == ~$past(din)));

  p_release_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (en_n && !en_n_prev && clr_n) |=> (q_n == $past(q_n)));

  p_write_others_r4: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr_n) |=>
      (((q_n ^ $past(q_n)) & ~(NUM_OUT'(1) << $past(sel))) == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (en_n && clr_n) |=> $stable(q_n));

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (en_n && !clr_n) |=> (q_n == {NUM_OUT{1'b1}}));

  p_demux_r7: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr_n) |=> (q_n == ~(NUM_OUT'($past(din)) << $past(sel))));

  p_sel_steady_r8: assert property (@(posedge clk) disable iff (rst)
    !en_n |-> $stable(sel));
endmodule

bind addr_latch_demux addr_latch_demux_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/addr_latch_demux_bench.sv
module addr_latch_demux_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       din;
  logic [2:0] sel;
  logic       en_n;
  logic       clr_n;
  logic [7:0] q_n;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  addr_latch_demux u_addr_latch_demux (
    .clk(clk), .rst(rst), .din(din), .sel(sel),
    .en_n(en_n), .clr_n(clr_n), .q_n(q_n)
  );

  // {req, en_n, clr_n, sel, din, expected q_n after one edge}
  localparam int NV = 25;
  localparam logic [17:0] VEC [NV] = '{
    {4'd5, 1'b1, 1'b1, 3'd0, 1'b0, 8'hFF},  // R5 hold after reset
    {4'd8, 1'b1, 1'b1, 3'd3, 1'b1, 8'hFF},  // R8 select move, enable high
    {4'd2, 1'b0, 1'b1, 3'd3, 1'b1, 8'hF7},  // R2 write line 3 on
    {4'd2, 1'b0, 1'b1, 3'd3, 1'b0, 8'hFF},  // R2 follows data
    {4'd2, 1'b0, 1'b1, 3'd3, 1'b1, 8'hF7},  // R2
    {4'd3, 1'b1, 1'b1, 3'd3, 1'b0, 8'hF7},  // R3 release keeps value
    {4'd8, 1'b1, 1'b1, 3'd6, 1'b1, 8'hF7},  // R8
    {4'd4, 1'b0, 1'b1, 3'd6, 1'b1, 8'hB7},  // R4 line 3 kept
    {4'd3, 1'b1, 1'b1, 3'd6, 1'b0, 8'hB7},  // R3
    {4'd5, 1'b1, 1'b1, 3'd0, 1'b1, 8'hB7},  // R5
    {4'd2, 1'b0, 1'b1, 3'd0, 1'b1, 8'hB6},  // R2 line 0
    {4'd5, 1'b1, 1'b1, 3'd7, 1'b1, 8'hB6},  // R5
    {4'd4, 1'b0, 1'b1, 3'd7, 1'b1, 8'h36},  // R4 line 7
    {4'd6, 1'b1, 1'b0, 3'd7, 1'b1, 8'hFF},  // R6 clear all
    {4'd5, 1'b1, 1'b1, 3'd2, 1'b0, 8'hFF},  // R5
    {4'd7, 1'b0, 1'b0, 3'd2, 1'b1, 8'hFB},  // R7 demux line 2
    {4'd7, 1'b0, 1'b0, 3'd2, 1'b0, 8'hFF},  // R7 data low
    {4'd7, 1'b0, 1'b0, 3'd2, 1'b1, 8'hFB},  // R7
    {4'd9, 1'b1, 1'b1, 3'd5, 1'b0, 8'hFB},  // R9 pattern kept
    {4'd9, 1'b0, 1'b1, 3'd5, 1'b1, 8'hDB},  // R9 write on top
    {4'd3, 1'b1, 1'b1, 3'd5, 1'b1, 8'hDB},  // R3
    {4'd6, 1'b1, 1'b0, 3'd1, 1'b1, 8'hFF},  // R6
    {4'd5, 1'b1, 1'b1, 3'd1, 1'b1, 8'hFF},  // R5
    {4'd7, 1'b0, 1'b0, 3'd1, 1'b1, 8'hFD},  // R7 line 1
    {4'd2, 1'b0, 1'b1, 3'd1, 1'b1, 8'hFD}   // R2
  };

  task automatic check(input int req, input logic [7:0] exp);
    n_checks++;
    if (q_n !== exp) begin
      n_errors++;
      $display("FAIL R%0d: q_n=%h expected=%h", req, q_n, exp);
    end
  endtask

  initial begin
    rst = 1'b1; din = 1'b0; sel = 3'd0; en_n = 1'b1; clr_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(1, 8'hFF);  // R1 reset state
    for (int i = 0; i < NV; i++) begin
      {en_n, clr_n, sel, din} = VEC[i][13:8];
      @(negedge clk);
      check(int'(VEC[i][17:14]), VEC[i][7:0]);
    end
    // R1: reset wins over a write in progress
    rst = 1'b1; en_n = 1'b0; clr_n = 1'b1; sel = 3'd1; din = 1'b1;
    @(negedge clk);
    check(1, 8'hFF);
    en_n = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1, 8'hFF);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule